// File: doc/BRIEF.md
# Functional Unit Issue Scoreboard

This block tracks which execution units of a core are occupied and decides, every cycle, which of several parallel operation requests can start. Each request lane carries a valid bit, a three-bit operation class, a destination tag and, for divides, a requested latency. The block grants a lane when a unit of the matching kind is free. It records the operation in that unit's occupancy state and later raises a completion pulse carrying the tag on the unit's own result port. No arithmetic is done here. The block models only occupancy and completion timing.

The unit pool is four integer units (simple ops and multiplies), two load units, one store unit, two floating-point multipliers, one floating-point adder, one integer divider and one floating-point divider. All of them except the two dividers are pipelined with a fixed latency per class. Each divider is held for a latency chosen per request and accepts nothing else until that operation has completed. Requests are served in lane order, so lane 0 has the highest priority.

Top module: `fu_scoreboard`

## Requirements
- R1: Class codes are ALU=0, IMUL=1, LOAD=2, STORE=3, FMUL=4, FADD=5, IDIV=6, FDIV=7. In one cycle the block accepts at most four ALU/IMUL, two LOAD, one STORE, two FMUL, one FADD, one IDIV and one FDIV, and different classes may be accepted together.
- R2: When more lanes request a class than there are free units, the lowest-numbered lanes are accepted. A lane with valid low is never accepted.
- R3: An operation accepted in cycle t with a fixed-latency class completes in cycle t+L, where L is 1 for ALU, 3 for IMUL, 4 for LOAD and STORE, 5 for FMUL and 3 for FADD.
- R4: Every pipelined unit can accept a new operation in each cycle, even while earlier operations are still in flight.
- R5: An integer unit refuses an operation whose completion cycle would equal that of an operation it already holds. An ALU op is therefore stalled on a unit whose multiply completes in the next cycle.
- R6: A divider that accepts in cycle t with latency L refuses all requests in cycles t+1 to t+L and is free again in cycle t+L+1.
- R7: The divide latency input is clamped to the range 3 to 30 for IDIV and 3 to 15 for FDIV.
- R8: A request that is not accepted changes no state. It produces no completion, and in-flight operations complete with their original tags and timing.
- R9: Each accepted operation produces exactly one completion pulse with its tag, on the port of its unit. Ports are ordered integer units 0-3, load 4-5, store 6, FMUL 7-8, FADD 9, IDIV 10 and FDIV 11, and simultaneous completions appear on separate ports.
- R10: Reset clears all occupancy. No completion is reported during or after reset for work started before it, and every unit is free in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | NUM_LANES | Request present, one bit per lane |
| reqClass | input | NUM_LANES x 3 | Operation class per lane |
| reqTag | input | NUM_LANES x 6 | Destination tag per lane |
| reqDivLat | input | NUM_LANES x 5 | Requested divide latency per lane |
| reqAccept | output | NUM_LANES | Lane granted this cycle |
| doneValid | output | 12 | Completion pulse, one bit per unit |
| doneTag | output | 12 x 6 | Tag of the completing operation per unit |

## Verification
The bench targets the boundaries of occupancy.

- **Store oversubscription:** three stores offered to the single store unit. A faulty arbiter grants a wrong lane or more than one.
- **Writeback collision:** an ALU burst is offered one cycle before a full set of multiplies completes. A design that ignores the collision grants it and emits doubled completions.
- **Divider release:** divides are offered while the divider is busy, and again exactly one cycle after a divider completes. An off-by-one release shows up as a wrong grant.
- **Latency clamping:** divide latencies of 0, 2 and 31 are requested. A design without clamping completes in the wrong cycle.
- **Reset mid-divide:** reset is applied during a long divide. A design that does not clear occupancy refuses the next divide or reports a stale tag.

// File: rtl/fu_sched_pkg.sv
`timescale 1ns/1ps
package fu_sched_pkg;

  localparam int TAG_W = 6;
  localparam int LAT_W = 5;
  localparam int CLS_W = 3;

  // unit counts per kind
  localparam int N_INT  = 4;
  localparam int N_LD   = 2;
  localparam int N_ST   = 1;
  localparam int N_FMUL = 2;
  localparam int N_FADD = 1;
  localparam int N_IDIV = 1;
  localparam int N_FDIV = 1;

  // port layout: each kind occupies a contiguous index range
  localparam int OFS_INT   = 0;
  localparam int OFS_LD    = OFS_INT + N_INT;
  localparam int OFS_ST    = OFS_LD + N_LD;
  localparam int OFS_FMUL  = OFS_ST + N_ST;
  localparam int OFS_FADD  = OFS_FMUL + N_FMUL;
  localparam int OFS_IDIV  = OFS_FADD + N_FADD;
  localparam int OFS_FDIV  = OFS_IDIV + N_IDIV;
  localparam int NUM_UNITS = OFS_FDIV + N_FDIV;

  // fixed latencies of pipelined classes
  localparam int LAT_ALU  = 1;
  localparam int LAT_IMUL = 3;
  localparam int LAT_LDST = 4;
  localparam int LAT_FMUL = 5;
  localparam int LAT_FADD = 3;

  // divide latency bounds
  localparam int IDIV_MIN = 3;
  localparam int IDIV_MAX = 30;
  localparam int FDIV_MIN = 3;
  localparam int FDIV_MAX = 15;

  function automatic int maxFixedLat();
    int m;
    m = LAT_ALU;
    if (LAT_IMUL > m) m = LAT_IMUL;
    if (LAT_LDST > m) m = LAT_LDST;
    if (LAT_FMUL > m) m = LAT_FMUL;
    if (LAT_FADD > m) m = LAT_FADD;
    return m;
  endfunction

  localparam int PIPE_DEPTH = maxFixedLat();
  localparam int SLOT_IDX_W = (PIPE_DEPTH > 1) ? $clog2(PIPE_DEPTH) : 1;

  typedef enum logic [CLS_W-1:0] {
    OP_ALU   = 3'd0,
    OP_IMUL  = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STORE = 3'd3,
    OP_FMUL  = 3'd4,
    OP_FADD  = 3'd5,
    OP_IDIV  = 3'd6,
    OP_FDIV  = 3'd7
  } opClass_e;

  typedef enum logic [2:0] {
    UK_INT, UK_LD, UK_ST, UK_FMUL, UK_FADD, UK_IDIV, UK_FDIV
  } unitKind_e;

  // strobe bundle from control to one unit of the datapath
  typedef struct packed {
    logic             go;
    logic [TAG_W-1:0] tag;
    logic [LAT_W-1:0] lat;
  } unitIssue_t;

  function automatic unitKind_e kindOfUnit(int u);
    if (u < OFS_LD)   return UK_INT;
    if (u < OFS_ST)   return UK_LD;
    if (u < OFS_FMUL) return UK_ST;
    if (u < OFS_FADD) return UK_FMUL;
    if (u < OFS_IDIV) return UK_FADD;
    if (u < OFS_FDIV) return UK_IDIV;
    return UK_FDIV;
  endfunction

  function automatic unitKind_e kindOfClass(opClass_e c);
    case (c)
      OP_ALU, OP_IMUL: return UK_INT;
      OP_LOAD:         return UK_LD;
      OP_STORE:        return UK_ST;
      OP_FMUL:         return UK_FMUL;
      OP_FADD:         return UK_FADD;
      OP_IDIV:         return UK_IDIV;
      default:         return UK_FDIV;
    endcase
  endfunction

  function automatic logic isDivKind(unitKind_e k);
    return (k == UK_IDIV) || (k == UK_FDIV);
  endfunction

  function automatic logic [LAT_W-1:0] clampLat(logic [LAT_W-1:0] d, int lo, int hi);
    if (d < LAT_W'(lo)) return LAT_W'(lo);
    if (d > LAT_W'(hi)) return LAT_W'(hi);
    return d;
  endfunction

  function automatic logic [LAT_W-1:0] latOfOp(opClass_e c, logic [LAT_W-1:0] divLat);
    case (c)
      OP_ALU:           return LAT_W'(LAT_ALU);
      OP_IMUL:          return LAT_W'(LAT_IMUL);
      OP_LOAD, OP_STORE: return LAT_W'(LAT_LDST);
      OP_FMUL:          return LAT_W'(LAT_FMUL);
      OP_FADD:          return LAT_W'(LAT_FADD);
      OP_IDIV:          return clampLat(divLat, IDIV_MIN, IDIV_MAX);
      default:          return clampLat(divLat, FDIV_MIN, FDIV_MAX);
    endcase
  endfunction

endpackage

// File: rtl/fu_pipe_slots.sv
`timescale 1ns/1ps
module fu_pipe_slots
  import fu_sched_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  unitIssue_t            issue,
  output logic [PIPE_DEPTH-1:0] occ,
  output logic                  doneValid,
  output logic [TAG_W-1:0]      doneTag
);

  // slot i holds an operation that completes i cycles from now
  logic [PIPE_DEPTH-1:0]            slotVld;
  logic [PIPE_DEPTH-1:0][TAG_W-1:0] slotTag;
  logic [PIPE_DEPTH-1:0]            shVld;
  logic [PIPE_DEPTH-1:0][TAG_W-1:0] shTag;

  always_comb begin
    shVld = slotVld >> 1;
    shTag = '0;
    for (int i = 0; i < PIPE_DEPTH - 1; i++) shTag[i] = slotTag[i+1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotVld <= '0;
      slotTag <= '0;
    end else begin
      for (int i = 0; i < PIPE_DEPTH; i++) begin
        if (issue.go && issue.lat == LAT_W'(i + 1)) begin
          slotVld[i] <= 1'b1;
          slotTag[i] <= issue.tag;
        end else begin
          slotVld[i] <= shVld[i];
          slotTag[i] <= shTag[i];
        end
      end
    end
  end

  assign occ       = slotVld;
  assign doneValid = slotVld[0];
  assign doneTag   = slotTag[0];

endmodule

// File: rtl/fu_div_timer.sv
`timescale 1ns/1ps
module fu_div_timer
  import fu_sched_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  unitIssue_t            issue,
  output logic [PIPE_DEPTH-1:0] occ,
  output logic                  doneValid,
  output logic [TAG_W-1:0]      doneTag
);

  logic [LAT_W-1:0] remain;
  logic [TAG_W-1:0] heldTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain  <= '0;
      heldTag <= '0;
    end else if (issue.go) begin
      remain  <= issue.lat;
      heldTag <= issue.tag;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  // bit 0 reports busy; the upper bits are unused for a divider
  assign occ       = {{(PIPE_DEPTH-1){1'b0}}, remain != '0};
  assign doneValid = (remain == LAT_W'(1));
  assign doneTag   = heldTag;

endmodule

// File: rtl/fu_issue_ctrl.sv
`timescale 1ns/1ps
module fu_issue_ctrl
  import fu_sched_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES-1:0]                  reqValid,
  input  logic [NUM_LANES-1:0][CLS_W-1:0]       reqClass,
  input  logic [NUM_LANES-1:0][TAG_W-1:0]       reqTag,
  input  logic [NUM_LANES-1:0][LAT_W-1:0]       reqDivLat,
  input  logic [NUM_UNITS-1:0][PIPE_DEPTH-1:0]  unitOcc,
  output logic [NUM_LANES-1:0]                  reqAccept,
  output unitIssue_t [NUM_UNITS-1:0]            issue
);

  logic [NUM_UNITS-1:0] claimed;
  opClass_e             cls;
  logic [LAT_W-1:0]     lat;
  logic                 free;

  always_comb begin
    claimed   = '0;
    reqAccept = '0;
    issue     = '0;
    cls       = OP_ALU;
    lat       = '0;
    free      = 1'b0;
    // lanes in ascending order: a lower lane claims units first
    for (int l = 0; l < NUM_LANES; l++) begin
      cls = opClass_e'(reqClass[l]);
      lat = latOfOp(cls, reqDivLat[l]);
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (isDivKind(kindOfUnit(u)))
          free = !unitOcc[u][0];
        else if (lat < LAT_W'(PIPE_DEPTH))
          // the slot that would shift into our landing slot must be empty
          free = !unitOcc[u][lat[SLOT_IDX_W-1:0]];
        else
          free = 1'b1;
        if (reqValid[l] && !reqAccept[l] && !claimed[u] &&
            kindOfUnit(u) == kindOfClass(cls) && free) begin
          claimed[u]   = 1'b1;
          reqAccept[l] = 1'b1;
          issue[u].go  = 1'b1;
          issue[u].tag = reqTag[l];
          issue[u].lat = lat;
        end
      end
    end
  end

endmodule

// File: rtl/fu_exec_datapath.sv
`timescale 1ns/1ps
module fu_exec_datapath
  import fu_sched_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  unitIssue_t [NUM_UNITS-1:0]            issue,
  output logic [NUM_UNITS-1:0][PIPE_DEPTH-1:0]  unitOcc,
  output logic [NUM_UNITS-1:0]                  doneValid,
  output logic [NUM_UNITS-1:0][TAG_W-1:0]       doneTag
);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    if (isDivKind(kindOfUnit(u))) begin : g_div
      fu_div_timer i_div (
        .clk       (clk),
        .rstN      (rstN),
        .issue     (issue[u]),
        .occ       (unitOcc[u]),
        .doneValid (doneValid[u]),
        .doneTag   (doneTag[u])
      );
    end else begin : g_pipe
      fu_pipe_slots i_pipe (
        .clk       (clk),
        .rstN      (rstN),
        .issue     (issue[u]),
        .occ       (unitOcc[u]),
        .doneValid (doneValid[u]),
        .doneTag   (doneTag[u])
      );
    end
  end

endmodule

// File: rtl/fu_scoreboard.sv
`timescale 1ns/1ps
module fu_scoreboard
  import fu_sched_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_LANES-1:0]             reqValid,
  input  logic [NUM_LANES-1:0][CLS_W-1:0]  reqClass,
  input  logic [NUM_LANES-1:0][TAG_W-1:0]  reqTag,
  input  logic [NUM_LANES-1:0][LAT_W-1:0]  reqDivLat,
  output logic [NUM_LANES-1:0]             reqAccept,
  output logic [NUM_UNITS-1:0]             doneValid,
  output logic [NUM_UNITS-1:0][TAG_W-1:0]  doneTag
);

  unitIssue_t [NUM_UNITS-1:0]           issue;
  logic [NUM_UNITS-1:0][PIPE_DEPTH-1:0] unitOcc;

  fu_issue_ctrl #(.NUM_LANES(NUM_LANES)) i_ctrl (
    .reqValid  (reqValid),
    .reqClass  (reqClass),
    .reqTag    (reqTag),
    .reqDivLat (reqDivLat),
    .unitOcc   (unitOcc),
    .reqAccept (reqAccept),
    .issue     (issue)
  );

  fu_exec_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .issue     (issue),
    .unitOcc   (unitOcc),
    .doneValid (doneValid),
    .doneTag   (doneTag)
  );

endmodule

// File: rtl/fu_scoreboard_chk.sv
`timescale 1ns/1ps
module fu_scoreboard_chk
  import fu_sched_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [NUM_LANES-1:0]             reqValid,
  input logic [NUM_LANES-1:0][CLS_W-1:0]  reqClass,
  input logic [NUM_LANES-1:0]             reqAccept,
  input logic [NUM_UNITS-1:0]             doneValid
);

  logic [NUM_LANES-1:0] accAlu, accLoad, accStore, accIdiv, accFdiv;

  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      accAlu[l]   = reqAccept[l] && reqClass[l] == OP_ALU;
      accLoad[l]  = reqAccept[l] && reqClass[l] == OP_LOAD;
      accStore[l] = reqAccept[l] && reqClass[l] == OP_STORE;
      accIdiv[l]  = reqAccept[l] && reqClass[l] == OP_IDIV;
      accFdiv[l]  = reqAccept[l] && reqClass[l] == OP_FDIV;
    end
  end

  a_r1_store_limit: assert property (@(posedge clk) disable iff (!rstN)
    $countones(accStore) <= N_ST);

  a_r1_load_limit: assert property (@(posedge clk) disable iff (!rstN)
    $countones(accLoad) <= N_LD);

  a_r2_grant_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccept & ~reqValid) == '0);

  a_r3_alu_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (|accAlu) |=> ($countones(doneValid[OFS_INT +: N_INT]) >= $past($countones(accAlu))));

  a_r6_idiv_held: assert property (@(posedge clk) disable iff (!rstN)
    (|accIdiv) |=> !(|accIdiv));

  a_r6_fdiv_held: assert property (@(posedge clk) disable iff (!rstN)
    (|accFdiv) |=> !(|accFdiv));

  a_r9_idiv_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid[OFS_IDIV] |=> !doneValid[OFS_IDIV]);

  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !rstN |-> doneValid == '0);

endmodule

bind fu_scoreboard fu_scoreboard_chk #(.NUM_LANES(NUM_LANES)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqClass  (reqClass),
  .reqAccept (reqAccept),
  .doneValid (doneValid)
);

// File: tb/test_fu_scoreboard.sv
`timescale 1ns/1ps
module test_fu_scoreboard;
  import fu_sched_pkg::*;

  localparam int NL = 4;
  localparam int NV = 20;
  localparam int RUN = 60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                    rstN;
  logic [NL-1:0]           reqValid;
  logic [NL-1:0][2:0]      reqClass;
  logic [NL-1:0][5:0]      reqTag;
  logic [NL-1:0][4:0]      reqDivLat;
  logic [NL-1:0]           reqAccept;
  logic [11:0]             doneValid;
  logic [11:0][5:0]        doneTag;

  fu_scoreboard #(.NUM_LANES(NL)) i_fu_scoreboard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqClass(reqClass),
    .reqTag(reqTag), .reqDivLat(reqDivLat), .reqAccept(reqAccept),
    .doneValid(doneValid), .doneTag(doneTag)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  function automatic logic [14:0] ln(bit v, int cls, int tag, int lat);
    return {v, 3'(cls), 6'(tag), 5'(lat)};
  endfunction

  localparam logic [14:0] NO = 15'd0;

  // lanes 0..3 from MSB, then expected grants {lane3,lane2,lane1,lane0}
  localparam logic [63:0] VEC [0:NV-1] = '{
    {ln(1,0,1,0),  ln(1,0,2,0),  ln(1,0,3,0),  ln(1,0,4,0),  4'b1111}, // R1 four ALU
    {ln(1,0,5,0),  ln(1,0,6,0),  ln(1,0,7,0),  ln(1,0,8,0),  4'b1111}, // R4 back to back
    {ln(1,2,9,0),  ln(1,2,10,0), ln(1,2,11,0), ln(1,3,12,0), 4'b1011}, // R1 R2 loads
    {ln(1,3,13,0), ln(1,3,14,0), ln(1,2,15,0), ln(1,5,16,0), 4'b1101}, // R2 store
    {ln(1,6,17,10),ln(1,7,18,2), ln(1,6,19,5), ln(1,4,20,0), 4'b1011}, // R7 low clamp
    {ln(1,6,21,3), ln(1,7,22,5), ln(1,4,23,0), ln(1,4,24,0), 4'b1100}, // R6 busy
    {ln(1,4,25,0), ln(1,4,26,0), ln(1,4,27,0), ln(1,5,28,0), 4'b1011}, // R4 fmul
    {ln(1,1,29,0), ln(1,1,30,0), ln(1,1,31,0), ln(1,1,32,0), 4'b1111}, // R3 imul
    {ln(1,0,33,0), ln(1,0,34,0), ln(1,0,35,0), ln(1,0,36,0), 4'b1111},
    {ln(1,0,37,0), ln(1,0,38,0), ln(1,0,39,0), ln(1,0,40,0), 4'b0000}, // R5 collision
    {ln(1,6,41,31),ln(1,7,42,31),ln(1,0,43,0), NO,           4'b0110}, // R8 R7 high clamp
    {NO, NO, NO, NO, 4'b0000},
    {NO, NO, NO, NO, 4'b0000},
    {NO, NO, NO, NO, 4'b0000},
    {NO, NO, NO, NO, 4'b0000},
    {ln(1,6,44,0), ln(1,6,45,7), ln(1,7,46,4), ln(1,2,47,0), 4'b1001}, // R6 release
    {NO, NO, NO, NO, 4'b0000},
    {NO, NO, NO, NO, 4'b0000},
    {NO, NO, NO, NO, 4'b0000},
    {ln(1,6,48,31),NO,           NO,           NO,           4'b0001}  // R6 R7
  };

  logic [63:0] expMask [0:127];

  function automatic int benchLat(int cls, int d);
    case (cls)
      0: return 1;
      1: return 3;
      2, 3: return 4;
      4: return 5;
      5: return 3;
      6: return (d < 3) ? 3 : (d > 30) ? 30 : d;
      default: return (d < 3) ? 3 : (d > 15) ? 15 : d;
    endcase
  endfunction

  task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] obsMask();
    logic [63:0] m = '0;
    for (int u = 0; u < 12; u++) if (doneValid[u]) m[doneTag[u]] = 1'b1;
    return m;
  endfunction

  task automatic clearReq();
    reqValid = '0; reqClass = '0; reqTag = '0; reqDivLat = '0;
  endtask

  initial begin
    #25000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) expMask[i] = '0;
    rstN = 1'b0;
    clearReq();
    repeat (3) @(negedge clk);
    #1;
    check(doneValid == '0, "R10 no completion in reset", 64'(doneValid), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // table walk: one vector per cycle, then idle cycles
    for (int k = 0; k < RUN; k++) begin
      logic [63:0] v;
      logic [63:0] m;
      if (k != 0) @(negedge clk);
      v = (k < NV) ? VEC[k] : 64'd0;
      for (int l = 0; l < NL; l++) begin
        reqValid[l]  = v[63-15*l];
        reqClass[l]  = v[62-15*l -: 3];
        reqTag[l]    = v[59-15*l -: 6];
        reqDivLat[l] = v[53-15*l -: 5];
      end
      #1;
      check(reqAccept == v[3:0], $sformatf("R1/R2/R4/R5/R6/R8 grants cycle %0d", k),
            64'(reqAccept), 64'(v[3:0]));
      for (int l = 0; l < NL; l++)
        if (v[l]) expMask[k + benchLat(int'(reqClass[l]), int'(reqDivLat[l]))][reqTag[l]] = 1'b1;
      m = obsMask();
      check(m == expMask[k], $sformatf("R3/R7/R8 completion tags cycle %0d", k), m, expMask[k]);
      check($countones(doneValid) == $countones(expMask[k]),
            $sformatf("R9 completion count cycle %0d", k),
            64'($countones(doneValid)), 64'($countones(expMask[k])));
    end

    // R10: reset during a long divide frees the divider and drops its tag
    @(negedge clk);
    clearReq();
    reqValid[0] = 1'b1; reqClass[0] = 3'd6; reqTag[0] = 6'd50; reqDivLat[0] = 5'd20;
    #1;
    check(reqAccept[0] == 1'b1, "R10 long divide granted", 64'(reqAccept), 64'd1);
    @(negedge clk);
    clearReq();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    reqValid[0] = 1'b1; reqClass[0] = 3'd6; reqTag[0] = 6'd51; reqDivLat[0] = 5'd3;
    #1;
    check(reqAccept[0] == 1'b1, "R10 divider free after reset", 64'(reqAccept), 64'd1);
    for (int i = 1; i <= 6; i++) begin
      logic [63:0] e;
      @(negedge clk);
      clearReq();
      #1;
      e = (i == 3) ? (64'd1 << 51) : 64'd0;
      check(obsMask() == e, $sformatf("R10 post-reset completion step %0d", i), obsMask(), e);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule